// File: doc/BRIEF.md
# PCM Sample Receive Buffer

This block sits between a PCM sample producer and a reader that is either a bus master or a DMA engine. Samples arrive one 24-bit word per write strobe and are kept in a 32-deep first-in first-out store. Each read strobe removes the oldest word. The word at the head of the store is presented continuously on the data output. A width select picks the output format. In wide format all 24 bits are passed through. In narrow format only the upper 16 bits of the stored sample are kept, placed in the low half-word and sign-extended above.

The block reports its fill state as a full flag, an empty flag and a 5-bit level. Because 5 bits cannot show 32, the level wraps to 0 when the store is full, and the full flag marks that case. A programmable threshold flag compares the stored count against a 5-bit setting. Its interrupt output and the DMA request each have their own enable. A two-bit clear field flushes the store only when the key value 11b is written. The field then returns to zero by itself. Register decode belongs to the surrounding bus logic, so only data, status and control signals are exposed.

Top module: `pcm_sample_fifo`

## Requirements
- R1: Words leave the buffer in the order they were written. In wide format (`wide_sel`=1) `rd_data` equals the full 24-bit stored word at the head.
- R2: The store holds 32 words. With 32 words held, `full` is 1 and `level` reads 0. Below that, `level` equals the stored count and `full` is 0.
- R3: A write while `full` is 1 is dropped and sets the sticky `overflow` flag. The flag stays set until a keyed clear or a reset.
- R4: A read while `empty` is 1 changes nothing. While empty, `rd_data` is zero.
- R5: `thr_flag` is 1 exactly when the stored count is greater than or equal to `thr_level`.
- R6: `thr_irq` equals `thr_flag` while `thr_ie` is 1, and is 0 otherwise.
- R7: `dma_req` is 1 while the buffer holds at least one word and `dma_en` is 1. It drops in the cycle after the last word is popped.
- R8: Writing `clr_key`=2'b11 with `clr_wr` makes `clr_field` read 2'b11 for one cycle. At the next edge the store empties, `level` becomes 0, `overflow` clears and `clr_field` returns to 0.
- R9: Any other key value written to the clear field leaves the contents unchanged. The field reads the written value for one cycle and then returns to 0.
- R10: In narrow format (`wide_sel`=0), `rd_data[15:0]` equals stored bits 23..8 and `rd_data[23:16]` copies stored bit 23.
- R11: After reset the buffer is empty, with `full`, `overflow`, `level`, `clr_field`, `dma_req` and `thr_irq` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push strobe from the sample producer |
| wr_data | input | 24 | Sample to push |
| rd_en | input | 1 | Pop strobe from the reader |
| rd_data | output | 24 | Head word, formatted by `wide_sel` |
| wide_sel | input | 1 | 1: 24-bit output, 0: 16-bit sign-extended output |
| clr_wr | input | 1 | Write strobe for the clear field |
| clr_key | input | 2 | Value written to the clear field (11b flushes) |
| clr_field | output | 2 | Current clear field contents |
| thr_level | input | 5 | Threshold count setting |
| thr_ie | input | 1 | Threshold interrupt enable |
| dma_en | input | 1 | DMA request enable |
| full | output | 1 | 32 words held |
| empty | output | 1 | No word held |
| level | output | 5 | Stored count modulo 32 |
| overflow | output | 1 | Sticky dropped-write flag |
| thr_flag | output | 1 | Count at or above threshold |
| thr_irq | output | 1 | Gated threshold interrupt |
| dma_req | output | 1 | Gated request for the DMA reader |

## Verification
The bench builds the block with its default parameters: 32 words of 24 bits and a 16-bit narrow field. At this size a full fill takes only 32 pushes, so the level wrap to 0 at full, the dropped write with its overflow flag, and a complete drain in narrow format are all reachable in a short run. Signed test words with bit 23 both set and clear exercise the sign extension in narrow format. A threshold of 0 and thresholds just above and at the count probe both sides of the comparison.

// File: rtl/pcm_sample_fifo.sv
module pcm_sample_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 24,
  parameter int NW    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  input  logic                       wide_sel,
  input  logic                       clr_wr,
  input  logic [1:0]                 clr_key,
  output logic [1:0]                 clr_field,
  input  logic [$clog2(DEPTH)-1:0]   thr_level,
  input  logic                       thr_ie,
  input  logic                       dma_en,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH)-1:0]   level,
  output logic                       overflow,
  output logic                       thr_flag,
  output logic                       thr_irq,
  output logic                       dma_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int XW = DW - NW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic [1:0]    clr_q;
  logic          ovf_q;

  wire clr_now = (clr_q == 2'b11);
  wire push    = wr_en && !full;
  wire pop     = rd_en && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      clr_q <= 2'b00;
      ovf_q <= 1'b0;
    end else begin
      clr_q <= clr_wr ? clr_key : 2'b00;
      if (clr_now) begin
        wptr  <= '0;
        rptr  <= '0;
        count <= '0;
        ovf_q <= 1'b0;
      end else begin
        if (push) wptr <= wptr + AW'(1);
        if (pop)  rptr <= rptr + AW'(1);
        count <= count + CW'(push) - CW'(pop);
        if (wr_en && full) ovf_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr_now) mem[wptr] <= wr_data;
  end

  wire [DW-1:0] head   = mem[rptr];
  wire [DW-1:0] narrow = {{XW{head[DW-1]}}, head[DW-1 -: NW]};

  assign rd_data   = empty ? '0 : (wide_sel ? head : narrow);
  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign level     = count[AW-1:0];
  assign overflow  = ovf_q;
  assign clr_field = clr_q;
  assign thr_flag  = (count >= {1'b0, thr_level});
  assign thr_irq   = thr_flag && thr_ie;
  assign dma_req   = !empty && dma_en;

  p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !clr_now) |=> (full && overflow));

  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_now) |=> overflow);

  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> empty);

  p_keyed_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> (empty && !overflow));

  p_field_autoclear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_field != 2'b00 && !clr_wr) |=> (clr_field == 2'b00));

  p_full_level_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (level == '0 && !empty));

endmodule

// File: tb/pcm_sample_fifo_tb.sv
module pcm_sample_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, wide_sel = 1'b1;
  logic        clr_wr = 1'b0, thr_ie = 1'b0, dma_en = 1'b0;
  logic [1:0]  clr_key = 2'b00;
  logic [4:0]  thr_level = 5'd0;
  logic [23:0] wr_data = '0;
  logic [23:0] rd_data;
  logic [1:0]  clr_field;
  logic        full, empty, overflow, thr_flag, thr_irq, dma_req;
  logic [4:0]  level;

  int total = 0;
  int bad = 0;
  logic [23:0] q[$];

  always #10 clk = ~clk;

  pcm_sample_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .wide_sel(wide_sel),
    .clr_wr(clr_wr), .clr_key(clr_key), .clr_field(clr_field),
    .thr_level(thr_level), .thr_ie(thr_ie), .dma_en(dma_en),
    .full(full), .empty(empty), .level(level), .overflow(overflow),
    .thr_flag(thr_flag), .thr_irq(thr_irq), .dma_req(dma_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] fmt(input logic [23:0] w, input logic wide);
    if (wide) return w;
    return {{8{w[23]}}, w[23:8]};
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic push(input logic [23:0] d, input bit expect_kept);
    wr_en = 1'b1;
    wr_data = d;
    if (expect_kept) q.push_back(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pop_one();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  // monitor: compares the head word against the scoreboard when a pop is presented
  always @(negedge clk) begin
    if (rst_n && rd_en && !empty) begin
      if (q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R1 actual=%0h expected=none (scoreboard empty)", rd_data);
      end else begin
        logic [23:0] e;
        e = fmt(q.pop_front(), wide_sel);
        check(wide_sel ? "R1 order/wide" : "R10 narrow format", {8'h0, rd_data}, {8'h0, e});
      end
    end
  end

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    // R11 reset state
    check("R11 empty", empty, 1);
    check("R11 full", full, 0);
    check("R11 level", level, 0);
    check("R11 overflow", overflow, 0);
    check("R11 clr_field", clr_field, 0);
    check("R11 dma_req", dma_req, 0);
    check("R11 thr_irq", thr_irq, 0);

    // five words, wide format
    for (int i = 0; i < 5; i++) push(24'h812345 + 24'h111111 * i, 1);
    check("R2 level 5", level, 5);
    thr_level = 5'd5;
    #1 check("R5 count>=thr", thr_flag, 1);
    check("R6 irq disabled", thr_irq, 0);
    thr_level = 5'd6;
    #1 check("R5 count<thr", thr_flag, 0);
    thr_level = 5'd4; thr_ie = 1'b1;
    #1 check("R6 irq enabled", thr_irq, 1);
    check("R7 dma disabled", dma_req, 0);
    dma_en = 1'b1;
    #1 check("R7 dma enabled", dma_req, 1);
    for (int i = 0; i < 5; i++) pop_one();
    check("R7 dma drops after last pop", dma_req, 0);
    check("R1 drained", empty, 1);
    thr_level = 5'd0;
    #1 check("R5 threshold zero", thr_flag, 1);

    // R4 read while empty
    check("R4 rd_data zero", rd_data, 0);
    pop_one();
    check("R4 still empty", empty, 1);
    check("R4 level", level, 0);

    // fill to 32 then overflow
    for (int i = 0; i < 32; i++) push({i[0] ? 8'hA5 : 8'h3C, i[7:0], 8'h5A ^ i[7:0]}, 1);
    check("R2 full", full, 1);
    check("R2 level wraps", level, 0);
    check("R3 no overflow yet", overflow, 0);
    push(24'hDEAD00, 0);
    check("R3 overflow set", overflow, 1);
    check("R3 still full", full, 1);
    wide_sel = 1'b0;
    for (int i = 0; i < 32; i++) pop_one();
    check("R3 dropped word absent", empty, 1);
    check("R3 overflow sticky", overflow, 1);
    wide_sel = 1'b1;

    // R9 non-key write
    for (int i = 0; i < 3; i++) push(24'h400000 + i, 1);
    clr_wr = 1'b1; clr_key = 2'b10;
    tick();
    clr_wr = 1'b0; clr_key = 2'b00;
    check("R9 field visible", clr_field, 2);
    tick();
    check("R9 field auto zero", clr_field, 0);
    check("R9 contents kept", level, 3);
    check("R9 overflow kept", overflow, 1);

    // R8 keyed clear
    clr_wr = 1'b1; clr_key = 2'b11;
    tick();
    clr_wr = 1'b0; clr_key = 2'b00;
    check("R8 field 11", clr_field, 3);
    tick();
    q.delete();
    check("R8 empty", empty, 1);
    check("R8 level", level, 0);
    check("R8 overflow cleared", overflow, 0);
    check("R8 field zero", clr_field, 0);

    // post-clear order still correct
    push(24'h7FFF00, 1);
    push(24'h800100, 1);
    wide_sel = 1'b0;
    pop_one();
    pop_one();
    check("R1 empty at end", empty, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule